// File: doc/BRIEF.md
# Video Clock Source Selector

This block picks the clock that feeds a video output engine and drives the matching pad. Four clocks arrive at it: a 27 MHz crystal clock, a PLL clock, an auxiliary bus clock and a clock received on a bidirectional pad. A six-bit control register, written through a single-cycle strobe in the crystal domain, holds the settings. It chooses the source, sets the pad direction, chooses separate or feedback routing, inverts the core clock and enables the core clock. The block produces a core clock, a pad output clock and a pad direction signal.

Every change of source goes through a handshake in the clock domains involved, so the output never shows a runt pulse. The outgoing clock is parked low before the incoming clock is released. Gating also happens while the gated clock is low. From reset until software first writes the register, the crystal clock drives the core whatever the register holds. After that, the direction bit takes priority over the source select. While an LCD-only input is high, feedback routing cannot be selected.

Top module: `vclk_sel_top`

## Requirements
- R1: During reset, and after reset until the first register write, clk_core runs at the crystal clock, pad_oe is 0 and clk_pad_out stays low.
- R2: With the direction bit at 0 (output mode), the select field picks the source for both clk_core and clk_pad_out: 00 is the crystal clock, 01 and 10 are the PLL clock, 11 is the auxiliary clock. pad_oe is 1 and clk_core is in phase with the source.
- R3: With the direction bit at 1 (input mode), clk_core comes from clk_pad_in for every select code, pad_oe is 0 and clk_pad_out stays low.
- R4: With the invert bit at 1, clk_core is the complement of its source and clk_pad_out is not inverted.
- R5: With the enable bit at 0, clk_core is held low and clk_pad_out keeps running.
- R6: With the feedback bit at 1, clk_core is taken from clk_pad_in while clk_pad_out still carries the selected internal source.
- R7: A write made while lcd_only is 1 stores the feedback bit as 0, whatever was written.
- R8: Across every source change, enable change and direction change, no high or low phase of clk_core or clk_pad_out is shorter than the shortest half-period among the sources involved.
- R9: The register changes only on a cycle with wr_en high. Its layout is: bit 0 invert, bit 1 feedback, bit 2 direction (1 = input), bits 4:3 select, bit 5 enable. The reset values are enable 1, direction 1, and all other bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_xtal | input | 1 | 27 MHz crystal clock; also clocks the register |
| clk_pll | input | 1 | PLL clock |
| clk_aux | input | 1 | Auxiliary bus clock |
| clk_pad_in | input | 1 | Clock received from the video clock pad |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, crystal domain |
| wr_data | input | 6 | Register write value |
| lcd_only | input | 1 | While high, blocks feedback routing |
| clk_core | output | 1 | Clock to the video core |
| clk_pad_out | output | 1 | Clock driven onto the pad |
| pad_oe | output | 1 | 1 when the pad drives clk_pad_out |

## Verification
Four properties are checked on every cycle. The source enables inside each selector stay one-hot-or-zero. The crystal source stays enabled on the core path until the first write. Without a strobe the register holds its value. A write made under lcd_only leaves the feedback bit clear. Frequency, phase, inversion, holding low and pad direction show only at the ports. The bench scenarios measure these there, timing edges against the source periods. A monitor times each phase of both output clocks while the scenarios switch between sources.

// File: rtl/vclk_pkg.sv
`timescale 1ns/1ps
package vclk_pkg;
  localparam int unsigned NUM_SRC = 4;
  localparam int unsigned SRC_W   = $clog2(NUM_SRC);

  localparam logic [SRC_W-1:0] SRC_XTAL = 2'd0;
  localparam logic [SRC_W-1:0] SRC_PLL  = 2'd1;
  localparam logic [SRC_W-1:0] SRC_AUX  = 2'd2;
  localparam logic [SRC_W-1:0] SRC_PAD  = 2'd3;

  typedef struct packed {
    logic       enable;  // bit 5
    logic [1:0] sel;     // bits 4:3
    logic       dir_in;  // bit 2, 1 = pad is an input
    logic       fb;      // bit 1
    logic       inv;     // bit 0
  } vclk_cfg_t;

  localparam int unsigned CFG_W = $bits(vclk_cfg_t);

  localparam vclk_cfg_t CFG_RESET = '{enable: 1'b1, sel: 2'b00, dir_in: 1'b1,
                                      fb: 1'b0, inv: 1'b0};
endpackage

// File: rtl/vclk_ctrl_reg.sv
`timescale 1ns/1ps
module vclk_ctrl_reg
  import vclk_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  input  logic             lcd_only,
  output vclk_cfg_t        cfg,
  output logic             written
);
  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[SYNC_STAGES-1];

  vclk_cfg_t cfg_q, cfg_d;
  logic      written_q, written_d;

  always_comb begin
    cfg_d     = cfg_q;
    written_d = written_q;
    if (wr_en) begin
      cfg_d     = vclk_cfg_t'(wr_data);
      cfg_d.fb  = wr_data[1] & ~lcd_only;
      written_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cfg_q     <= CFG_RESET;
      written_q <= 1'b0;
    end else begin
      cfg_q     <= cfg_d;
      written_q <= written_d;
    end
  end

  assign cfg     = cfg_q;
  assign written = written_q;

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(cfg_q));

  p_fb_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && lcd_only) |=> !cfg_q.fb);
endmodule

// File: rtl/vclk_glitchless_mux.sv
`timescale 1ns/1ps
module vclk_glitchless_mux #(
  parameter int unsigned N       = 4,
  parameter int unsigned IW      = $clog2(N),
  parameter int unsigned RST_IDX = 0,
  parameter int unsigned STAGES  = 2
) (
  input  logic [N-1:0]  clk_in,
  input  logic          rst_n,
  input  logic [IW-1:0] sel,
  output logic          clk_out,
  output logic [N-1:0]  en_out
);
  logic [N-1:0] en_q;
  logic [N-1:0] gated;

  for (genvar i = 0; i < N; i++) begin : g_src
    localparam logic [N-1:0] SELF = N'(1) << i;
    localparam logic [STAGES-1:0] RST_VAL = (i == RST_IDX) ? '1 : '0;
    logic              want;
    logic [STAGES-1:0] sync_q, sync_d;

    // Claim this source only when every other source has let go.
    assign want = (sel == IW'(i)) && ((en_q & ~SELF) == '0);

    always_comb begin
      sync_d = {sync_q[STAGES-2:0], want};
    end

    // Falling-edge stages: the enable moves only while this clock is low.
    always_ff @(negedge clk_in[i] or negedge rst_n) begin
      if (!rst_n) sync_q <= RST_VAL;
      else        sync_q <= sync_d;
    end

    assign en_q[i]  = sync_q[STAGES-1];
    assign gated[i] = clk_in[i] & en_q[i];
  end

  assign clk_out = |gated;
  assign en_out  = en_q;

  p_onehot_r8: assert property (@(posedge clk_in[RST_IDX]) disable iff (!rst_n)
    $onehot0(en_q));
endmodule

// File: rtl/vclk_core_gate.sv
`timescale 1ns/1ps
module vclk_core_gate #(
  parameter bit          EN_RST = 1'b1,
  parameter int unsigned STAGES = 2
) (
  input  logic clk_raw,
  input  logic rst_n,
  input  logic en_async,
  input  logic inv,
  output logic clk_gated
);
  logic [STAGES-1:0] en_neg_q, en_neg_d;
  logic [STAGES-1:0] en_pos_q, en_pos_d;

  always_comb begin
    en_neg_d = {en_neg_q[STAGES-2:0], en_async};
    en_pos_d = {en_pos_q[STAGES-2:0], en_async};
  end

  // Enable for the true clock moves while the true clock is low.
  always_ff @(negedge clk_raw or negedge rst_n) begin
    if (!rst_n) en_neg_q <= {STAGES{EN_RST}};
    else        en_neg_q <= en_neg_d;
  end

  // Enable for the inverted clock moves while the inverted clock is low.
  always_ff @(posedge clk_raw or negedge rst_n) begin
    if (!rst_n) en_pos_q <= {STAGES{EN_RST}};
    else        en_pos_q <= en_pos_d;
  end

  assign clk_gated = inv ? (en_pos_q[STAGES-1] & ~clk_raw)
                         : (en_neg_q[STAGES-1] &  clk_raw);
endmodule

// File: rtl/vclk_sel_top.sv
`timescale 1ns/1ps
module vclk_sel_top
  import vclk_pkg::*;
(
  input  logic             clk_xtal,
  input  logic             clk_pll,
  input  logic             clk_aux,
  input  logic             clk_pad_in,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  input  logic             lcd_only,
  output logic             clk_core,
  output logic             clk_pad_out,
  output logic             pad_oe
);
  vclk_cfg_t          cfg;
  logic               written;
  logic [SRC_W-1:0]   src_idx, core_idx;
  logic [NUM_SRC-1:0] clk_vec;
  logic [NUM_SRC-1:0] core_en, pad_en;
  logic               core_raw, pad_raw;

  vclk_ctrl_reg u_reg (
    .clk      (clk_xtal),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .lcd_only (lcd_only),
    .cfg      (cfg),
    .written  (written)
  );

  // Priority: untouched register > input mode > select field.
  always_comb begin
    if (!written)        src_idx = SRC_XTAL;
    else if (cfg.dir_in) src_idx = SRC_PAD;
    else begin
      unique case (cfg.sel)
        2'b00:   src_idx = SRC_XTAL;
        2'b11:   src_idx = SRC_AUX;
        default: src_idx = SRC_PLL;
      endcase
    end
    core_idx = cfg.fb ? SRC_PAD : src_idx;
  end

  assign clk_vec = {clk_pad_in, clk_aux, clk_pll, clk_xtal};
  assign pad_oe  = written & ~cfg.dir_in;

  vclk_glitchless_mux #(.N(NUM_SRC), .IW(SRC_W), .RST_IDX(SRC_XTAL)) u_core_mux (
    .clk_in  (clk_vec),
    .rst_n   (rst_n),
    .sel     (core_idx),
    .clk_out (core_raw),
    .en_out  (core_en)
  );

  vclk_glitchless_mux #(.N(NUM_SRC), .IW(SRC_W), .RST_IDX(SRC_XTAL)) u_pad_mux (
    .clk_in  (clk_vec),
    .rst_n   (rst_n),
    .sel     (src_idx),
    .clk_out (pad_raw),
    .en_out  (pad_en)
  );

  vclk_core_gate #(.EN_RST(1'b1)) u_core_gate (
    .clk_raw   (core_raw),
    .rst_n     (rst_n),
    .en_async  (cfg.enable),
    .inv       (cfg.inv),
    .clk_gated (clk_core)
  );

  vclk_core_gate #(.EN_RST(1'b0)) u_pad_gate (
    .clk_raw   (pad_raw),
    .rst_n     (rst_n),
    .en_async  (pad_oe),
    .inv       (1'b0),
    .clk_gated (clk_pad_out)
  );

  p_forced_r1: assert property (@(posedge clk_xtal) disable iff (!rst_n)
    !written |-> core_en[SRC_XTAL]);
endmodule

// File: tb/vclk_sel_top_bench.sv
`timescale 1ns/1ps
module vclk_sel_top_bench;
  localparam int CLK_PERIOD = 36;
  localparam int PLL_HALF   = 5;
  localparam int AUX_HALF   = 7;
  localparam int PAD_HALF   = 11;
  localparam real MIN_PHASE = 4.99;

  logic clk_xtal = 0, clk_pll = 0, clk_aux = 0, clk_pad_in = 0;
  logic rst_n = 0, wr_en = 0, lcd_only = 0;
  logic [5:0] wr_data = '0;
  logic clk_core, clk_pad_out, pad_oe;

  int errors = 0, checks = 0;
  bit mon_on = 0, done = 0;
  realtime core_prev = 0, core_last = 0, pad_prev = 0, pad_last = 0;
  realtime core_edge = 0, pad_edge = 0;
  int core_rises = 0, pad_rises = 0, glitches = 0;

  always #(CLK_PERIOD/2) clk_xtal = ~clk_xtal;
  always #(PLL_HALF)     clk_pll  = ~clk_pll;
  always #(AUX_HALF)     clk_aux  = ~clk_aux;
  always #(PAD_HALF)     clk_pad_in = ~clk_pad_in;

  vclk_sel_top u_vclk_sel_top (
    .clk_xtal(clk_xtal), .clk_pll(clk_pll), .clk_aux(clk_aux),
    .clk_pad_in(clk_pad_in), .rst_n(rst_n), .wr_en(wr_en),
    .wr_data(wr_data), .lcd_only(lcd_only), .clk_core(clk_core),
    .clk_pad_out(clk_pad_out), .pad_oe(pad_oe)
  );

  always @(posedge clk_core) begin
    core_prev = core_last; core_last = $realtime; core_rises++;
  end
  always @(posedge clk_pad_out) begin
    pad_prev = pad_last; pad_last = $realtime; pad_rises++;
  end
  // R8 phase monitor
  always @(clk_core) begin
    if (mon_on && ($realtime - core_edge) < MIN_PHASE) glitches++;
    core_edge = $realtime;
  end
  always @(clk_pad_out) begin
    if (mon_on && ($realtime - pad_edge) < MIN_PHASE) glitches++;
    pad_edge = $realtime;
  end

  function automatic logic [5:0] cfgw(bit en, logic [1:0] sel, bit dir_in, bit fb, bit inv);
    return {en, sel, dir_in, fb, inv};
  endfunction

  task automatic chk(string req, string what, real act, real exp);
    checks++;
    if (act > exp + 0.01 || act < exp - 0.01) begin
      errors++;
      $display("FAIL %s %s: actual=%0.2f expected=%0.2f", req, what, act, exp);
    end
  endtask

  task automatic settle();
    repeat (40) @(negedge clk_xtal);
  endtask

  task automatic write_cfg(logic [5:0] d);
    @(negedge clk_xtal); wr_en = 1; wr_data = d;
    @(negedge clk_xtal); wr_en = 0;
    settle();
  endtask

  task automatic core_period(string req, real exp);
    chk(req, "clk_core period", real'(core_last - core_prev), exp);
  endtask
  task automatic pad_period(string req, real exp);
    chk(req, "clk_pad_out period", real'(pad_last - pad_prev), exp);
  endtask
  task automatic pad_quiet(string req);
    int n0 = pad_rises;
    repeat (10) @(negedge clk_xtal);
    chk(req, "clk_pad_out rises", real'(pad_rises - n0), 0.0);
    chk(req, "clk_pad_out level", real'(clk_pad_out), 0.0);
  endtask

  task automatic t_reset();
    chk("R1", "pad_oe", real'(pad_oe), 0.0);
    core_period("R1", 2.0 * CLK_PERIOD/2);
    pad_quiet("R1");
  endtask

  task automatic t_no_strobe();
    @(negedge clk_xtal); wr_data = cfgw(1, 2'b01, 0, 0, 0);
    settle();
    chk("R9", "pad_oe without strobe", real'(pad_oe), 0.0);
    core_period("R9", CLK_PERIOD);
  endtask

  task automatic t_output_sel();
    write_cfg(cfgw(1, 2'b01, 0, 0, 0));
    chk("R2", "pad_oe", real'(pad_oe), 1.0);
    core_period("R2", 2*PLL_HALF); pad_period("R2", 2*PLL_HALF);
    @(posedge clk_pll); #1;
    chk("R2", "core in phase", real'(clk_core), 1.0);
    write_cfg(cfgw(1, 2'b10, 0, 0, 0));
    core_period("R2", 2*PLL_HALF);
    write_cfg(cfgw(1, 2'b11, 0, 0, 0));
    core_period("R2", 2*AUX_HALF); pad_period("R2", 2*AUX_HALF);
    write_cfg(cfgw(1, 2'b00, 0, 0, 0));
    core_period("R2", CLK_PERIOD); pad_period("R2", CLK_PERIOD);
  endtask

  task automatic t_input_mode();
    write_cfg(cfgw(1, 2'b00, 1, 0, 0));
    chk("R3", "pad_oe", real'(pad_oe), 0.0);
    core_period("R3", 2*PAD_HALF);
    pad_quiet("R3");
    write_cfg(cfgw(1, 2'b11, 1, 0, 0));
    core_period("R3", 2*PAD_HALF);
  endtask

  task automatic t_invert();
    write_cfg(cfgw(0, 2'b01, 0, 0, 0));
    write_cfg(cfgw(1, 2'b01, 0, 0, 1));
    core_period("R4", 2*PLL_HALF);
    @(posedge clk_pll); #1;
    chk("R4", "core inverted", real'(clk_core), 0.0);
    chk("R4", "pad not inverted", real'(clk_pad_out), 1.0);
    write_cfg(cfgw(0, 2'b01, 0, 0, 1));
    write_cfg(cfgw(1, 2'b01, 0, 0, 0));
  endtask

  task automatic t_disable();
    int n0;
    write_cfg(cfgw(0, 2'b11, 0, 0, 0));
    n0 = core_rises;
    repeat (10) @(negedge clk_xtal);
    chk("R5", "clk_core rises", real'(core_rises - n0), 0.0);
    chk("R5", "clk_core level", real'(clk_core), 0.0);
    pad_period("R5", 2*AUX_HALF);
    write_cfg(cfgw(1, 2'b11, 0, 0, 0));
    core_period("R5", 2*AUX_HALF);
  endtask

  task automatic t_feedback();
    lcd_only = 0;
    write_cfg(cfgw(1, 2'b01, 0, 1, 0));
    core_period("R6", 2*PAD_HALF); pad_period("R6", 2*PLL_HALF);
    write_cfg(cfgw(1, 2'b01, 0, 0, 0));
    lcd_only = 1;
    write_cfg(cfgw(1, 2'b01, 0, 1, 0));
    core_period("R7", 2*PLL_HALF);
    lcd_only = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 3 + 5);
    rst_n = 1;
    settle();
    mon_on = 1;
    t_reset();
    t_no_strobe();
    t_output_sel();
    t_input_mode();
    t_invert();
    t_disable();
    t_feedback();
    write_cfg(cfgw(1, 2'b00, 1, 0, 0));
    chk("R8", "short phases", real'(glitches), 0.0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule